// File: doc/BRIEF.md
# Secure Stage-2 Translation Control Register

This block holds the 64-bit control word for the second stage of address translation in the secure world and answers accesses to it from the system-register port. Each access carries an encoded selector, a direction, the current exception level, the security state, three nested-virtualization control bits and an enable for secure EL2 coming from EL3. A combinational decoder classifies the access as permitted, undefined, trapped to EL2 with a syndrome class, or redirected to a fixed slot in memory. Only a permitted write changes the stored word, one clock after the request.

The stored word forces its reserved bits on every write. Four effective controls come from it: the output address space, the walk address space, the granule size and the initial lookup level. These are not always the bits that read back. A set walk-space bit forces the output space to non-secure. A reserved or unsupported granule code falls back to 4KB. The start level comes from one decode of the level selector, the level extension bit and the granule, and a reserved combination raises a level-0 fault flag. The block also reports the log2 of the region size.

Top module: `s2_sec_xlat_ctl`

## Requirements
- R1: After reset the word reads 0x0000_0000_8000_0000, and the effective outputs are secure output space, secure walk space, 4KB granule, start level 2, no fault.
- R2: A write stores only bits 33 (level extension, when LARGE_ADDR=1), 30 (output space), 29 (walk space), 15:14 (granule), 7:6 (level selector) and 5:0 (size offset). Every other bit reads 0, except bit 31, which always reads 1.
- R3: When bit 29 is 1, eff_oa_nonsec_o is 1 whatever bit 30 holds, and a read still returns bit 30 as written.
- R4: Granule code 00 selects 4KB, 01 selects 64KB and 10 selects 16KB. On eff_gran_o these use the same codes. Code 11, or a size disabled by parameter, gives 4KB on eff_gran_o, while a read returns the programmed code.
- R5: With the 4KB granule and no extension, level selector values 00, 01, 10 and 11 give start levels 2, 1, 0 and 3.
- R6: With 16KB or 64KB, selector values 00, 01 and 10 give levels 3, 2 and 1. Selector 11 gives level 0 for 16KB when LARGE_ADDR=1, and for 64KB it raises lvl_fault_o.
- R7: The level extension bit counts only when LARGE_ADDR=1, wide_desc_i=1 and the effective granule is 4KB. In that case selector 00 gives level -1 (start_lvl_o=3'b111) and any other selector raises lvl_fault_o. When lvl_fault_o is raised, start_lvl_o is 0.
- R8: An access from EL0 (cur_el_i=0) is undefined. An access from EL1 or EL2 with secure_i=0 is undefined.
- R9: An access from EL3 is undefined when sec_el2_en_i=0 and is performed otherwise. An access from secure EL2 is performed.
- R10: At secure EL1, nest_ctl_i bits 2 and 0 both set raises redirect_o with redirect_off_o=0x048. Otherwise, bit 0 set raises trap_o with trap_ec_o=0x18. Otherwise the access is undefined.
- R11: A write whose outcome is undefined, trap or redirect leaves the word unchanged. An access whose selector differs from REG_SEL raises no outcome and changes nothing.
- R12: region_log2_o equals 64 minus the stored size offset (bits 5:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access request this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_sel_i | input | 16 | Encoded register selector |
| acc_wdata_i | input | 64 | Write data |
| cur_el_i | input | 2 | Current exception level, 0 to 3 |
| secure_i | input | 1 | 1 = secure state |
| nest_ctl_i | input | 3 | Nested-virtualization controls; bit 0 enable, bit 2 memory redirect |
| sec_el2_en_i | input | 1 | EL3 enable for secure EL2 |
| wide_desc_i | input | 1 | Wide descriptor mode, gates the level extension |
| rdata_o | output | 64 | Read data for a permitted read, else 0 |
| undef_o | output | 1 | Access is undefined |
| trap_o | output | 1 | Access traps to EL2 |
| trap_ec_o | output | 6 | Syndrome class of the trap |
| redirect_o | output | 1 | Access goes to memory |
| redirect_off_o | output | 12 | Memory slot offset |
| eff_oa_nonsec_o | output | 1 | Effective output address space, 1 = non-secure |
| eff_walk_nonsec_o | output | 1 | Walk address space, 1 = non-secure |
| eff_gran_o | output | 2 | Effective granule code |
| start_lvl_o | output | 3 | Initial lookup level, two's complement |
| lvl_fault_o | output | 1 | Reserved start-level combination |
| region_log2_o | output | 7 | log2 of region size in bytes |

## Verification
The bench sets the walk-space bit with the output-space bit clear. A design that passed the raw bit through would report secure output while walking non-secure. Granule code 11 is written and read back. A wrong design would either echo an invalid granule on the effective output or rewrite the read-back value. The level extension bit is driven with wide descriptors on and off and under each granule, which catches a decoder that yields level -1 where the bit should be ignored. Every blocked write is followed by a permitted read, so a design that latches data on trapped, redirected or undefined writes is caught.

// File: rtl/s2xc_pkg.sv
`timescale 1ns/1ps
package s2xc_pkg;
  localparam int REG_W   = 64;
  localparam int LVL_W   = 3;
  localparam int SZ_W    = 6;

  localparam int POS_EXT  = 33;
  localparam int POS_ONE  = 31;
  localparam int POS_OA   = 30;
  localparam int POS_WALK = 29;
  localparam int POS_GR   = 14;
  localparam int POS_LS   = 6;

  typedef enum logic [1:0] {
    GRAN_4K  = 2'b00,
    GRAN_64K = 2'b01,
    GRAN_16K = 2'b10,
    GRAN_RSV = 2'b11
  } gran_e;

  typedef enum logic [1:0] {
    EL_0 = 2'd0,
    EL_1 = 2'd1,
    EL_2 = 2'd2,
    EL_3 = 2'd3
  } el_e;
endpackage

// File: rtl/s2xc_access_dec.sv
`timescale 1ns/1ps
module s2xc_access_dec
  import s2xc_pkg::*;
#(
  parameter logic [15:0] REG_SEL   = 16'hE132,
  parameter logic [5:0]  TRAP_EC   = 6'h18,
  parameter logic [11:0] REDIR_OFF = 12'h048
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        acc_valid_i,
  input  logic [15:0] acc_sel_i,
  input  logic [1:0]  cur_el_i,
  input  logic        secure_i,
  input  logic [2:0]  nest_ctl_i,
  input  logic        sec_el2_en_i,
  output logic        ok_o,
  output logic        undef_o,
  output logic        trap_o,
  output logic [5:0]  trap_ec_o,
  output logic        redirect_o,
  output logic [11:0] redirect_off_o
);
  logic hit;
  assign hit = acc_valid_i && (acc_sel_i == REG_SEL);

  always_comb begin
    ok_o       = 1'b0;
    undef_o    = 1'b0;
    trap_o     = 1'b0;
    redirect_o = 1'b0;
    if (hit) begin
      unique case (el_e'(cur_el_i))
        EL_0: undef_o = 1'b1;
        EL_1: begin
          if (!secure_i)                       undef_o    = 1'b1;
          else if (nest_ctl_i[2] && nest_ctl_i[0]) redirect_o = 1'b1;
          else if (nest_ctl_i[0])              trap_o     = 1'b1;
          else                                 undef_o    = 1'b1;
        end
        EL_2: begin
          if (!secure_i) undef_o = 1'b1;
          else           ok_o    = 1'b1;
        end
        EL_3: begin
          if (!sec_el2_en_i) undef_o = 1'b1;
          else               ok_o    = 1'b1;
        end
        default: undef_o = 1'b1;
      endcase
    end
  end

  assign trap_ec_o      = trap_o ? TRAP_EC : 6'd0;
  assign redirect_off_o = redirect_o ? REDIR_OFF : 12'd0;

  // R8
  el0_undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && cur_el_i == 2'd0) |-> (undef_o && !ok_o));

  // R10
  outcome_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_o, undef_o, trap_o, redirect_o}));
endmodule

// File: rtl/s2xc_reg_store.sv
`timescale 1ns/1ps
module s2xc_reg_store
  import s2xc_pkg::*;
#(
  parameter bit LARGE_ADDR = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  localparam logic [REG_W-1:0] ONE_BITS  = REG_W'(1) << POS_ONE;
  localparam logic [REG_W-1:0] BASE_MASK =
      (REG_W'(1) << POS_OA) | (REG_W'(1) << POS_WALK) |
      (REG_W'(3) << POS_GR) | (REG_W'(3) << POS_LS) |
      REG_W'((1 << SZ_W) - 1);
  localparam logic [REG_W-1:0] WMASK =
      BASE_MASK | (LARGE_ADDR ? (REG_W'(1) << POS_EXT) : '0);

  logic [REG_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= ONE_BITS;
    else if (wr_en_i) q <= (wdata_i & WMASK) | ONE_BITS;
  end

  assign q_o = q;

  // R2
  res_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q & ~WMASK) == ONE_BITS);
endmodule

// File: rtl/s2xc_eff_decode.sv
`timescale 1ns/1ps
module s2xc_eff_decode
  import s2xc_pkg::*;
#(
  parameter bit LARGE_ADDR  = 1'b1,
  parameter bit GRAN_16K_OK = 1'b1,
  parameter bit GRAN_64K_OK = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] q_i,
  input  logic             wide_desc_i,
  output logic             eff_oa_nonsec_o,
  output logic             eff_walk_nonsec_o,
  output logic [1:0]       eff_gran_o,
  output logic [LVL_W-1:0] start_lvl_o,
  output logic             lvl_fault_o,
  output logic [6:0]       region_log2_o
);
  gran_e      gran;
  logic [1:0] ls;
  logic       ext;

  assign eff_walk_nonsec_o = q_i[POS_WALK];
  assign eff_oa_nonsec_o   = q_i[POS_OA] | q_i[POS_WALK];
  assign ls                = q_i[POS_LS +: 2];

  always_comb begin
    unique case (gran_e'(q_i[POS_GR +: 2]))
      GRAN_64K: gran = GRAN_64K_OK ? GRAN_64K : GRAN_4K;
      GRAN_16K: gran = GRAN_16K_OK ? GRAN_16K : GRAN_4K;
      default:  gran = GRAN_4K;
    endcase
  end
  assign eff_gran_o = gran;

  assign ext = LARGE_ADDR && wide_desc_i && (gran == GRAN_4K) && q_i[POS_EXT];

  always_comb begin
    start_lvl_o = '0;
    lvl_fault_o = 1'b0;
    if (gran == GRAN_4K) begin
      if (ext) begin
        if (ls == 2'b00) start_lvl_o = 3'b111;
        else             lvl_fault_o = 1'b1;
      end else begin
        unique case (ls)
          2'b00: start_lvl_o = 3'd2;
          2'b01: start_lvl_o = 3'd1;
          2'b10: start_lvl_o = 3'd0;
          default: start_lvl_o = 3'd3;
        endcase
      end
    end else begin
      unique case (ls)
        2'b00: start_lvl_o = 3'd3;
        2'b01: start_lvl_o = 3'd2;
        2'b10: start_lvl_o = 3'd1;
        default: begin
          if (LARGE_ADDR && gran == GRAN_16K) start_lvl_o = 3'd0;
          else                                lvl_fault_o = 1'b1;
        end
      endcase
    end
  end

  assign region_log2_o = 7'd64 - {1'b0, q_i[SZ_W-1:0]};

  // R3
  sa_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_walk_nonsec_o |-> eff_oa_nonsec_o);

  // R7
  ext_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_desc_i || eff_gran_o != 2'b00) |-> (start_lvl_o != 3'b111));

  // R7
  fault_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_fault_o |-> (start_lvl_o == 3'd0));
endmodule

// File: rtl/s2_sec_xlat_ctl.sv
`timescale 1ns/1ps
module s2_sec_xlat_ctl
  import s2xc_pkg::*;
#(
  parameter bit          LARGE_ADDR  = 1'b1,
  parameter bit          GRAN_16K_OK = 1'b1,
  parameter bit          GRAN_64K_OK = 1'b1,
  parameter logic [15:0] REG_SEL     = 16'hE132,
  parameter logic [5:0]  TRAP_EC     = 6'h18,
  parameter logic [11:0] REDIR_OFF   = 12'h048
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        acc_valid_i,
  input  logic        acc_write_i,
  input  logic [15:0] acc_sel_i,
  input  logic [63:0] acc_wdata_i,
  input  logic [1:0]  cur_el_i,
  input  logic        secure_i,
  input  logic [2:0]  nest_ctl_i,
  input  logic        sec_el2_en_i,
  input  logic        wide_desc_i,
  output logic [63:0] rdata_o,
  output logic        undef_o,
  output logic        trap_o,
  output logic [5:0]  trap_ec_o,
  output logic        redirect_o,
  output logic [11:0] redirect_off_o,
  output logic        eff_oa_nonsec_o,
  output logic        eff_walk_nonsec_o,
  output logic [1:0]  eff_gran_o,
  output logic [2:0]  start_lvl_o,
  output logic        lvl_fault_o,
  output logic [6:0]  region_log2_o
);
  logic             acc_ok;
  logic [REG_W-1:0] q;

  s2xc_access_dec #(
    .REG_SEL  (REG_SEL),
    .TRAP_EC  (TRAP_EC),
    .REDIR_OFF(REDIR_OFF)
  ) u_dec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .acc_valid_i   (acc_valid_i),
    .acc_sel_i     (acc_sel_i),
    .cur_el_i      (cur_el_i),
    .secure_i      (secure_i),
    .nest_ctl_i    (nest_ctl_i),
    .sec_el2_en_i  (sec_el2_en_i),
    .ok_o          (acc_ok),
    .undef_o       (undef_o),
    .trap_o        (trap_o),
    .trap_ec_o     (trap_ec_o),
    .redirect_o    (redirect_o),
    .redirect_off_o(redirect_off_o)
  );

  s2xc_reg_store #(
    .LARGE_ADDR(LARGE_ADDR)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(acc_ok && acc_write_i),
    .wdata_i(acc_wdata_i),
    .q_o    (q)
  );

  s2xc_eff_decode #(
    .LARGE_ADDR (LARGE_ADDR),
    .GRAN_16K_OK(GRAN_16K_OK),
    .GRAN_64K_OK(GRAN_64K_OK)
  ) u_eff (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .q_i              (q),
    .wide_desc_i      (wide_desc_i),
    .eff_oa_nonsec_o  (eff_oa_nonsec_o),
    .eff_walk_nonsec_o(eff_walk_nonsec_o),
    .eff_gran_o       (eff_gran_o),
    .start_lvl_o      (start_lvl_o),
    .lvl_fault_o      (lvl_fault_o),
    .region_log2_o    (region_log2_o)
  );

  assign rdata_o = (acc_ok && !acc_write_i) ? q : '0;

  // R11
  blocked_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && !acc_ok) |=> $stable(q));
endmodule

// File: tb/s2_sec_xlat_ctl_bench.sv
`timescale 1ns/1ps
module s2_sec_xlat_ctl_bench;
  localparam logic [15:0] SEL = 16'hE132;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [15:0] sel = SEL;
  logic [63:0] wdata = '0;
  logic [1:0]  el = 2'd2;
  logic        sec = 1'b1, e2en = 1'b1, wide = 1'b0;
  logic [2:0]  nest = 3'd0;
  logic [63:0] rdata;
  logic        undef, trap, redir, oa, walk, fault;
  logic [5:0]  ec;
  logic [11:0] roff;
  logic [1:0]  gran;
  logic [2:0]  lvl;
  logic [6:0]  rlog;

  int n_tests = 0, n_fail = 0;
  logic [63:0] c_rdata;
  logic c_undef, c_trap, c_redir;
  logic [5:0] c_ec;
  logic [11:0] c_roff;

  always #2 clk = ~clk;

  s2_sec_xlat_ctl u_s2_sec_xlat_ctl (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_write_i(wr),
    .acc_sel_i(sel), .acc_wdata_i(wdata), .cur_el_i(el), .secure_i(sec),
    .nest_ctl_i(nest), .sec_el2_en_i(e2en), .wide_desc_i(wide),
    .rdata_o(rdata), .undef_o(undef), .trap_o(trap), .trap_ec_o(ec),
    .redirect_o(redir), .redirect_off_o(roff), .eff_oa_nonsec_o(oa),
    .eff_walk_nonsec_o(walk), .eff_gran_o(gran), .start_lvl_o(lvl),
    .lvl_fault_o(fault), .region_log2_o(rlog)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] e, input logic s,
                     input logic [2:0] n, input logic en2, input logic [15:0] sl,
                     input logic [63:0] d);
    @(negedge clk);
    wr = w; el = e; sec = s; nest = n; e2en = en2; sel = sl; wdata = d; valid = 1'b1;
    #1;
    c_rdata = rdata; c_undef = undef; c_trap = trap; c_redir = redir;
    c_ec = ec; c_roff = roff;
    @(negedge clk);
    valid = 1'b0; wr = 1'b0;
    #1;
  endtask

  task automatic wr_reg(input logic [63:0] d);
    acc(1'b1, 2'd2, 1'b1, 3'd0, 1'b1, SEL, d);
  endtask

  task automatic rd_reg(output logic [63:0] v);
    acc(1'b0, 2'd2, 1'b1, 3'd0, 1'b1, SEL, '0);
    v = c_rdata;
  endtask

  function automatic logic [63:0] mk(input logic x, input logic a, input logic w,
                                     input logic [1:0] g, input logic [1:0] l,
                                     input logic [5:0] z);
    logic [63:0] v = '0;
    v[33] = x; v[30] = a; v[29] = w; v[15:14] = g; v[7:6] = l; v[5:0] = z;
    return v;
  endfunction

  task automatic t_reset();
    logic [63:0] v;
    chk("R1 oa", 64'(oa), 64'd0);
    chk("R1 walk", 64'(walk), 64'd0);
    chk("R1 gran", 64'(gran), 64'd0);
    chk("R1 lvl", 64'(lvl), 64'd2);
    chk("R1 fault", 64'(fault), 64'd0);
    rd_reg(v);
    chk("R1 read", v, 64'h0000_0000_8000_0000);
  endtask

  task automatic t_mask();
    logic [63:0] v;
    wr_reg('1);
    rd_reg(v);
    chk("R2 all ones", v, 64'h0000_0002_E000_C0FF);
    chk("R12 sz 63", 64'(rlog), 64'd1);
    wr_reg('0);
    rd_reg(v);
    chk("R2 zeros", v, 64'h0000_0000_8000_0000);
    chk("R12 sz 0", 64'(rlog), 64'd64);
    wr_reg(mk(0, 0, 0, 2'b00, 2'b00, 6'd24));
    chk("R12 sz 24", 64'(rlog), 64'd40);
  endtask

  task automatic t_sa();
    logic [63:0] v;
    wr_reg(mk(0, 0, 1, 2'b00, 2'b00, 6'd0));
    chk("R3 oa forced", 64'(oa), 64'd1);
    chk("R3 walk", 64'(walk), 64'd1);
    rd_reg(v);
    chk("R3 readback", v, 64'h0000_0000_A000_0000);
    wr_reg(mk(0, 1, 0, 2'b00, 2'b00, 6'd0));
    chk("R3 oa only", 64'({oa, walk}), 64'b10);
  endtask

  task automatic t_gran();
    logic [63:0] v;
    wr_reg(mk(0, 0, 0, 2'b01, 2'b00, 6'd0));
    chk("R4 64k", 64'(gran), 64'd1);
    wr_reg(mk(0, 0, 0, 2'b10, 2'b00, 6'd0));
    chk("R4 16k", 64'(gran), 64'd2);
    wr_reg(mk(0, 0, 0, 2'b11, 2'b00, 6'd0));
    chk("R4 rsv eff", 64'(gran), 64'd0);
    rd_reg(v);
    chk("R4 rsv read", 64'(v[15:14]), 64'd3);
  endtask

  task automatic t_lvl4k();
    logic [2:0] exp4 [4] = '{3'd2, 3'd1, 3'd0, 3'd3};
    for (int i = 0; i < 4; i++) begin
      wr_reg(mk(0, 0, 0, 2'b00, 2'(i), 6'd20));
      chk("R5 4k lvl", 64'({fault, lvl}), 64'({1'b0, exp4[i]}));
    end
  endtask

  task automatic t_lvl_big();
    logic [2:0] expb [3] = '{3'd3, 3'd2, 3'd1};
    for (int i = 0; i < 3; i++) begin
      wr_reg(mk(0, 0, 0, 2'b10, 2'(i), 6'd20));
      chk("R6 16k lvl", 64'({fault, lvl}), 64'({1'b0, expb[i]}));
      wr_reg(mk(0, 0, 0, 2'b01, 2'(i), 6'd20));
      chk("R6 64k lvl", 64'({fault, lvl}), 64'({1'b0, expb[i]}));
    end
    wr_reg(mk(0, 0, 0, 2'b10, 2'b11, 6'd20));
    chk("R6 16k sel3", 64'({fault, lvl}), 64'd0);
    wr_reg(mk(0, 0, 0, 2'b01, 2'b11, 6'd20));
    chk("R6 64k sel3 fault", 64'({fault, lvl}), 64'b1000);
  endtask

  task automatic t_ext();
    wide = 1'b1;
    wr_reg(mk(1, 0, 0, 2'b00, 2'b00, 6'd12));
    chk("R7 lvl -1", 64'({fault, lvl}), 64'b0111);
    wr_reg(mk(1, 0, 0, 2'b00, 2'b01, 6'd12));
    chk("R7 rsv fault", 64'({fault, lvl}), 64'b1000);
    wr_reg(mk(1, 0, 0, 2'b10, 2'b00, 6'd12));
    chk("R7 16k ignores ext", 64'({fault, lvl}), 64'd3);
    wide = 1'b0;
    wr_reg(mk(1, 0, 0, 2'b00, 2'b00, 6'd12));
    chk("R7 narrow ignores ext", 64'({fault, lvl}), 64'd2);
  endtask

  task automatic t_priv();
    acc(1'b0, 2'd0, 1'b1, 3'd0, 1'b1, SEL, '0);
    chk("R8 el0", 64'({c_undef, c_rdata}), {1'b1, 64'd0});
    acc(1'b0, 2'd1, 1'b0, 3'd5, 1'b1, SEL, '0);
    chk("R8 el1 nonsec", 64'({c_undef, c_redir, c_trap}), 64'b100);
    acc(1'b0, 2'd2, 1'b0, 3'd0, 1'b1, SEL, '0);
    chk("R8 el2 nonsec", 64'(c_undef), 64'd1);
  endtask

  task automatic t_el3();
    logic [63:0] v;
    acc(1'b1, 2'd3, 1'b1, 3'd0, 1'b0, SEL, mk(0, 0, 0, 2'b10, 2'b01, 6'd5));
    chk("R9 el3 gated", 64'(c_undef), 64'd1);
    acc(1'b1, 2'd3, 1'b0, 3'd0, 1'b1, SEL, mk(0, 0, 0, 2'b10, 2'b01, 6'd5));
    chk("R9 el3 ok", 64'(c_undef), 64'd0);
    rd_reg(v);
    chk("R9 el3 write landed", v, 64'h0000_0000_8000_8045);
  endtask

  task automatic t_nest();
    acc(1'b0, 2'd1, 1'b1, 3'b101, 1'b1, SEL, '0);
    chk("R10 redirect", 64'({c_redir, c_roff}), {51'd0, 1'b1, 12'h048});
    acc(1'b0, 2'd1, 1'b1, 3'b111, 1'b1, SEL, '0);
    chk("R10 redirect 111", 64'(c_redir), 64'd1);
    acc(1'b0, 2'd1, 1'b1, 3'b001, 1'b1, SEL, '0);
    chk("R10 trap", 64'({c_trap, c_ec}), 64'({1'b1, 6'h18}));
    acc(1'b0, 2'd1, 1'b1, 3'b011, 1'b1, SEL, '0);
    chk("R10 trap 011", 64'({c_trap, c_redir}), 64'b10);
    acc(1'b0, 2'd1, 1'b1, 3'b100, 1'b1, SEL, '0);
    chk("R10 undef", 64'({c_undef, c_trap, c_redir}), 64'b100);
  endtask

  task automatic t_block();
    logic [63:0] v, d;
    d = mk(0, 1, 1, 2'b01, 2'b10, 6'd33);
    wr_reg(64'h8000_0000);
    acc(1'b1, 2'd0, 1'b1, 3'd0, 1'b1, SEL, d);
    acc(1'b1, 2'd1, 1'b1, 3'b001, 1'b1, SEL, d);
    acc(1'b1, 2'd1, 1'b1, 3'b101, 1'b1, SEL, d);
    acc(1'b1, 2'd2, 1'b0, 3'd0, 1'b1, SEL, d);
    rd_reg(v);
    chk("R11 blocked writes", v, 64'h0000_0000_8000_0000);
    acc(1'b1, 2'd2, 1'b1, 3'd0, 1'b1, 16'hE131, d);
    chk("R11 other sel quiet", 64'({c_undef, c_trap, c_redir}), 64'd0);
    rd_reg(v);
    chk("R11 other sel no write", v, 64'h0000_0000_8000_0000);
    chk("R11 eff unchanged", 64'({oa, walk, gran}), 64'd0);
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_mask();
    t_sa();
    t_gran();
    t_lvl4k();
    t_lvl_big();
    t_ext();
    t_priv();
    t_el3();
    t_nest();
    t_block();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule